// File: doc/BRIEF.md
# Instruction Extension Space Classifier

This block looks at one 32-bit instruction word at a time and reports which opcode region reserved for future extension the word lies in. The regions are undefined, arithmetic, control, load/store, coprocessor and unconditional, plus a "none" result for ordinary words. A decoder front end uses it to decide whether a fetched word must raise an undefined-instruction trap, has unpredictable behaviour, or may go on to normal decode.

Classification follows the decode-bit rule of the newest architecture version. The decode bits are bits[27:20], bits[7:4], and a flag that is set when the condition field bits[31:28] is all ones. If the decode bits match no allocated instruction, the word is UNDEFINED. If the decode bits match an allocated instruction but the whole word is not a valid encoding of it, the word is UNPREDICTABLE.

A word presented with its valid strobe is classified through one register stage. The result appears one clock later, together with a one-cycle result-valid pulse. For the arithmetic and control regions the block also reports whether the decode bits hit an allocated instruction.

Top module: `ext_space_classifier`

## Requirements
- R1: When `inValid` is high at a rising edge, `outValid` is high during the next cycle and the outputs show that word's result. When `inValid` is low at a rising edge, `outValid` is low in the next cycle and `spaceOneHot`, `status` and `allocMatch` keep their previous values.
- R2: While reset is asserted, and after it until the first captured word, `outValid`, `spaceOneHot`, `status` and `allocMatch` are all zero.
- R3: The bits of `spaceOneHot` are: 0 none, 1 undefined region, 2 arithmetic, 3 control, 4 load/store, 5 coprocessor, 6 unconditional. Exactly one bit is set for every result. `status` is 00 for defined, 01 for UNDEFINED and 10 for UNPREDICTABLE, and never 11.
- R4: A word with bits[31:28]=1111 is in the unconditional region, whatever its other bits are. Inside this region the following words are defined: bits[27:25]=101, bits[27:25]=110 and bits[27:24]=1110. A preload pattern is also accepted: bits[27:26]=01, bit[24]=1 and bits[22:20]=101. A preload pattern is defined when bits[15:12]=1111 and UNPREDICTABLE otherwise. Every other word in this region is UNDEFINED.
- R5: Any other word with bits[27:25]=011 and bit[4]=1 is in the undefined region with status UNDEFINED.
- R6: A word with bits[27:24]=0000 and bits[7:4]=1001 is in the arithmetic region. Its op1 field is bits[23:21]. op1 values 000, 001, 100, 101, 110 and 111 give defined status with `allocMatch`=1. op1 values 010 and 011 give UNDEFINED status with `allocMatch`=0.
- R7: A word with bits[27:25]=000, bit[7]=1, bit[4]=1 and not (bit[24]=0 with bits[6:5]=00) is in the load/store region, unless R6 applies first. It is defined when bits[6:5]!=00. It is also defined when bits[6:5]=00 and bits[23], [21] and [20] are all 0 (swap). Every other word in this region is UNDEFINED.
- R8: A word with bits[27:26]=00, bits[24:23]=10 and bit[20]=0 that no earlier rule claims is in the control region. With bit[25]=1, the word is allocated when bit[21]=1. With bit[25]=0, f stands for bits[7:4] and o for bits[22:21], and the allocated combinations are:
  - f=0000 with any o;
  - f=0001 with o=01 or o=11;
  - f=0011 with o=01;
  - f=0101 with any o;
  - f=0111 with o=01;
  - f=1xx0 with any o.

  An allocated word sets `allocMatch`=1 and has defined status. A word that is not allocated has `allocMatch`=0 and UNDEFINED status.
- R9: A control-region word with bit[25]=0, bits[7:4]=0000 and bit[21]=0 (status-register read form) but with bits[11:0] not zero is UNPREDICTABLE, and `allocMatch` stays 1.
- R10: A word with bits[27:23]=11000 and bit[21]=0 that no earlier rule claims is in the coprocessor region. It is defined when bit[22]=1 and UNDEFINED when bit[22]=0.
- R11: A word that no rule above claims is reported as none (bit 0), with defined status and `allocMatch`=0.
- R12: Where regions overlap, the order of priority is: unconditional, undefined, arithmetic, load/store, control, coprocessor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Word strobe |
| inWord | input | 32 | Instruction word to classify |
| outValid | output | 1 | One-cycle pulse: result of the previous strobed word |
| spaceOneHot | output | 7 | Region of the word, one-hot (R3) |
| status | output | 2 | 00 defined, 01 UNDEFINED, 10 UNPREDICTABLE |
| allocMatch | output | 1 | Decode bits hit an allocated arithmetic or control instruction |

## Verification
The result registers are the only state in this block. A wrong value in them shows at the ports on the cycle after the strobe. It appears as a wrong region bit, as more than one region bit set, or as a status code out of range. A bad hold path shows as outputs that drift while no word is strobed, or as a missing or doubled `outValid` pulse. The bench therefore compares every field one cycle after each strobe, and again after idle cycles. Overlap vectors are included so that any change to the priority order is exposed on the first word that falls in two regions.

// File: rtl/ext_space_pkg.sv
package ext_space_pkg;

  localparam int NUM_SPACES = 7;
  localparam int SPACE_IDX_W = $clog2(NUM_SPACES);

  typedef enum logic [SPACE_IDX_W-1:0] {
    SP_NONE   = 3'd0,
    SP_UNDEF  = 3'd1,
    SP_ARITH  = 3'd2,
    SP_CTRL   = 3'd3,
    SP_LDST   = 3'd4,
    SP_COPROC = 3'd5,
    SP_UNCOND = 3'd6
  } space_e;

  typedef enum logic [1:0] {
    ST_DEFINED   = 2'b00,
    ST_UNDEFINED = 2'b01,
    ST_UNPRED    = 2'b10
  } status_e;

  typedef struct packed {
    logic capture;
  } strobe_t;

endpackage

// File: rtl/ext_space_ctrl.sv
module ext_space_ctrl
  import ext_space_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    outValid
);

  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R1
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  pulse_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/ext_space_datapath.sv
module ext_space_datapath
  import ext_space_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [WORD_W-1:0]     inWord,
  output logic [NUM_SPACES-1:0] spaceOneHot,
  output logic [1:0]            status,
  output logic                  allocMatch
);

  localparam int COND_HI = WORD_W - 1;
  localparam int COND_LO = WORD_W - 4;

  logic [WORD_W-1:0] w;
  assign w = inWord;

  logic condAll;
  logic undefRegion, arithRegion, ldstRegion, ctrlRegion, copRegion;
  logic arithAlloc, ldstAlloc, ctrlAlloc, mrsForm, pldForm;
  logic [3:0] fBits;
  logic [1:0] oBits;

  space_e  spaceSel;
  status_e statusNext;
  logic    allocNext;
  logic [NUM_SPACES-1:0] spaceNext;

  assign condAll     = &w[COND_HI:COND_LO];
  assign fBits       = w[7:4];
  assign oBits       = w[22:21];

  // region detectors
  assign undefRegion = (w[27:25] == 3'b011) && w[4];
  assign arithRegion = (w[27:24] == 4'b0000) && (fBits == 4'b1001);
  assign ldstRegion  = (w[27:25] == 3'b000) && w[7] && w[4]
                       && !(!w[24] && (w[6:5] == 2'b00));
  assign ctrlRegion  = (w[27:26] == 2'b00) && (w[24:23] == 2'b10) && !w[20]
                       && !(!w[25] && w[7] && w[4]);
  assign copRegion   = (w[27:23] == 5'b11000) && !w[21];

  // allocation inside regions
  assign arithAlloc = (w[23:22] != 2'b01);
  assign ldstAlloc  = (w[6:5] != 2'b00) || (!w[23] && (w[21:20] == 2'b00));
  assign pldForm    = (w[27:26] == 2'b01) && w[24] && (w[22:20] == 3'b101);
  assign mrsForm    = !w[25] && (fBits == 4'b0000) && !oBits[0];

  always_comb begin
    ctrlAlloc = 1'b0;
    if (w[25]) begin
      ctrlAlloc = oBits[0];
    end else begin
      unique casez (fBits)
        4'b0000: ctrlAlloc = 1'b1;
        4'b0001: ctrlAlloc = oBits[0];
        4'b0011: ctrlAlloc = (oBits == 2'b01);
        4'b0101: ctrlAlloc = 1'b1;
        4'b0111: ctrlAlloc = (oBits == 2'b01);
        4'b1??0: ctrlAlloc = 1'b1;
        default: ctrlAlloc = 1'b0;
      endcase
    end
  end

  // priority resolution
  always_comb begin
    spaceSel   = SP_NONE;
    statusNext = ST_DEFINED;
    allocNext  = 1'b0;
    if (condAll) begin
      spaceSel = SP_UNCOND;
      if (pldForm)
        statusNext = (w[15:12] == 4'hF) ? ST_DEFINED : ST_UNPRED;
      else if ((w[27:25] == 3'b101) || (w[27:25] == 3'b110) || (w[27:24] == 4'b1110))
        statusNext = ST_DEFINED;
      else
        statusNext = ST_UNDEFINED;
    end else if (undefRegion) begin
      spaceSel   = SP_UNDEF;
      statusNext = ST_UNDEFINED;
    end else if (arithRegion) begin
      spaceSel   = SP_ARITH;
      allocNext  = arithAlloc;
      statusNext = arithAlloc ? ST_DEFINED : ST_UNDEFINED;
    end else if (ldstRegion) begin
      spaceSel   = SP_LDST;
      statusNext = ldstAlloc ? ST_DEFINED : ST_UNDEFINED;
    end else if (ctrlRegion) begin
      spaceSel  = SP_CTRL;
      allocNext = ctrlAlloc;
      if (!ctrlAlloc)                        statusNext = ST_UNDEFINED;
      else if (mrsForm && (w[11:0] != '0))   statusNext = ST_UNPRED;
      else                                   statusNext = ST_DEFINED;
    end else if (copRegion) begin
      spaceSel   = SP_COPROC;
      statusNext = w[22] ? ST_DEFINED : ST_UNDEFINED;
    end
  end

  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_onehot
    assign spaceNext[i] = (spaceSel == space_e'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spaceOneHot <= '0;
      status      <= 2'b00;
      allocMatch  <= 1'b0;
    end else if (strobe.capture) begin
      spaceOneHot <= spaceNext;
      status      <= statusNext;
      allocMatch  <= allocNext;
    end
  end

  // R3
  status_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'b11);

  // R3
  space_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(spaceOneHot));

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(spaceOneHot) && $stable(status) && $stable(allocMatch));

  // R6 R8
  alloc_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocMatch |-> (spaceOneHot[SP_ARITH] || spaceOneHot[SP_CTRL]));

endmodule

// File: rtl/ext_space_classifier.sv
module ext_space_classifier
  import ext_space_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [WORD_W-1:0]     inWord,
  output logic                  outValid,
  output logic [NUM_SPACES-1:0] spaceOneHot,
  output logic [1:0]            status,
  output logic                  allocMatch
);

  strobe_t strobe;

  ext_space_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ext_space_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inWord      (inWord),
    .spaceOneHot (spaceOneHot),
    .status      (status),
    .allocMatch  (allocMatch)
  );

  // R3
  result_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $onehot(spaceOneHot));

  // R4 R12
  uncond_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (spaceOneHot[SP_UNCOND] == ($past(inWord[WORD_W-1:WORD_W-4]) == 4'hF)));

endmodule

// File: tb/tb_ext_space_classifier.sv
module tb_ext_space_classifier;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;

  typedef struct packed {
    logic [31:0] word;
    logic [2:0]  sp;
    logic [1:0]  st;
    logic        al;
    logic [3:0]  req;
  } vec_t;

  // sp: 0 none,1 undef,2 arith,3 ctrl,4 ldst,5 coproc,6 uncond; st: 0 def,1 undef,2 unpred
  localparam vec_t VECS [NV] = '{
    '{32'hE0000091, 3'd2, 2'd0, 1'b1, 4'd6},   // R6 op1 000
    '{32'hE0400091, 3'd2, 2'd1, 1'b0, 4'd6},   // R6 op1 010
    '{32'hE0E00091, 3'd2, 2'd0, 1'b1, 4'd6},   // R6 op1 111
    '{32'hE0600091, 3'd2, 2'd1, 1'b0, 4'd6},   // R6 op1 011
    '{32'hE7F000F0, 3'd1, 2'd1, 1'b0, 4'd5},   // R5
    '{32'hE6000000, 3'd0, 2'd0, 1'b0, 4'd11},  // R11 bit4 clear
    '{32'hE10F0000, 3'd3, 2'd0, 1'b1, 4'd8},   // R8 status read
    '{32'hE10F0800, 3'd3, 2'd2, 1'b1, 4'd9},   // R9 bit11 set
    '{32'hE12FFF1E, 3'd3, 2'd0, 1'b1, 4'd8},   // R8 f=0001 o=01
    '{32'hE1000010, 3'd3, 2'd1, 1'b0, 4'd8},   // R8 f=0001 o=00
    '{32'hE16F0F11, 3'd3, 2'd0, 1'b1, 4'd8},   // R8 f=0001 o=11
    '{32'hE1200070, 3'd3, 2'd0, 1'b1, 4'd8},   // R8 f=0111 o=01
    '{32'hE1400070, 3'd3, 2'd1, 1'b0, 4'd8},   // R8 f=0111 o=10
    '{32'hE1000080, 3'd3, 2'd0, 1'b1, 4'd8},   // R8 f=1000
    '{32'hE1000030, 3'd3, 2'd1, 1'b0, 4'd8},   // R8 f=0011 o=00
    '{32'hE328F00F, 3'd3, 2'd0, 1'b1, 4'd8},   // R8 immediate o=01
    '{32'hE300000F, 3'd3, 2'd1, 1'b0, 4'd8},   // R8 immediate o=00
    '{32'hE1D000B0, 3'd4, 2'd0, 1'b0, 4'd7},   // R7 halfword
    '{32'hE1020090, 3'd4, 2'd0, 1'b0, 4'd12},  // R12 swap over control
    '{32'hE1200090, 3'd4, 2'd1, 1'b0, 4'd7},   // R7 bit21 set
    '{32'hE0C000D0, 3'd4, 2'd0, 1'b0, 4'd7},   // R7 bit24 clear, 6:5=10
    '{32'hEC400000, 3'd5, 2'd0, 1'b0, 4'd10},  // R10 bit22 set
    '{32'hEC000000, 3'd5, 2'd1, 1'b0, 4'd10},  // R10 bit22 clear
    '{32'hEC200000, 3'd0, 2'd0, 1'b0, 4'd11},  // R11 bit21 set
    '{32'hF5D0F000, 3'd6, 2'd0, 1'b0, 4'd4},   // R4 preload
    '{32'hF5D01000, 3'd6, 2'd2, 1'b0, 4'd4},   // R4 preload bad field
    '{32'hFA000000, 3'd6, 2'd0, 1'b0, 4'd4},   // R4 101
    '{32'hF0000091, 3'd6, 2'd1, 1'b0, 4'd12},  // R12 over arithmetic
    '{32'hFE000000, 3'd6, 2'd0, 1'b0, 4'd4},   // R4 1110
    '{32'hF7F000F0, 3'd6, 2'd1, 1'b0, 4'd12},  // R12 over undefined
    '{32'hEA000000, 3'd0, 2'd0, 1'b0, 4'd11},  // R11 branch
    '{32'hE0810002, 3'd0, 2'd0, 1'b0, 4'd11}   // R11 add
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic [6:0]  spaceOneHot;
  logic [1:0]  status;
  logic        allocMatch;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_space_classifier dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .spaceOneHot(spaceOneHot), .status(status),
    .allocMatch(allocMatch)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic v, input logic [6:0] sp,
                          input logic [1:0] st, input logic al);
    check({tag, " outValid"}, {31'b0, outValid}, {31'b0, v});
    check({tag, " space"}, {25'b0, spaceOneHot}, {25'b0, sp});
    check({tag, " status"}, {30'b0, status}, {30'b0, st});
    check({tag, " alloc"}, {31'b0, allocMatch}, {31'b0, al});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R2 during reset", 1'b0, 7'd0, 2'd0, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkAll("R2 after reset", 1'b0, 7'd0, 2'd0, 1'b0);

    // table walk, back to back
    for (int i = 0; i < NV; i++) begin
      inValid = 1'b1;
      inWord  = VECS[i].word;
      @(negedge clk);
      checkAll($sformatf("R%0d vec%0d R3 R1", VECS[i].req, i), 1'b1,
               7'(1) << VECS[i].sp, VECS[i].st, VECS[i].al);
    end

    // R1 hold while idle, with garbage on inWord
    inValid = 1'b0;
    inWord  = 32'hE0000091;
    repeat (3) @(negedge clk);
    checkAll("R1 idle hold", 1'b0, 7'b0000001, 2'd0, 1'b0);

    // R1 single strobe then idle: pulse lasts one cycle
    inValid = 1'b1;
    inWord  = 32'hEC000000;
    @(negedge clk);
    inValid = 1'b0;
    inWord  = 32'hF5D01000;
    checkAll("R1 pulse", 1'b1, 7'b0100000, 2'd1, 1'b0);
    @(negedge clk);
    checkAll("R1 pulse end", 1'b0, 7'b0100000, 2'd1, 1'b0);

    // R9 other nonzero low bits
    inValid = 1'b1;
    inWord  = 32'hE14F0001;
    @(negedge clk);
    checkAll("R9 low bit", 1'b1, 7'b0001000, 2'd2, 1'b1);

    // R2 reset mid-run clears outputs
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    checkAll("R2 mid reset", 1'b0, 7'd0, 2'd0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule